// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block is a passive protocol monitor for a two-bank SDRAM command bus. Every clock it samples the chip-select, row strobe, column strobe, write-enable, clock-enable, bank-select and A10 pins. It decodes the command and keeps a model of each bank: idle, open, or waiting for an auto-precharge to start. It also keeps the programmed burst length. With that model it checks every command against the minimum spacing rules. All minimum spacings are parameters counted in clock cycles.

When a command breaks a rule, the checker raises `err_valid` for one cycle and places a code for the broken rule on `err_code`. Both outputs are registered, so the report for the command sampled at clock edge N is visible between edge N and edge N+1. The checker drives nothing onto the memory bus. It is placed beside a controller or a memory model in simulation or in silicon.

Top module: `sdram_cmd_checker`

## Requirements
- R1: A command is taken only when chip select is low and clock enable was high at the previous edge. The pins {ras_n,cas_n,we_n} decode as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop, 111 no-op. A deselected cycle, a no-op, or any cycle while clock enable was low produces no error and changes no bank.
- R2: An activate to a bank that is already open reports code 1.
- R3: An activate to a bank whose precharge has not begun, or began fewer than TRP cycles earlier, reports code 2. The precharge may be explicit or automatic.
- R4: An activate fewer than TRC cycles after the previous activate of the same bank reports code 3.
- R5: An activate fewer than TRRD cycles after an activate of the other bank reports code 4.
- R6: A read or write fewer than TRCD cycles after its bank's activate reports code 5.
- R7: A read or write to a bank that is not open reports code 6. A bank is not open while its auto-precharge is pending.
- R8: A precharge with A10 high closes both banks. With A10 low it closes only the bank on `ba`.
- R9: A read or write with A10 high closes the bank and schedules its precharge. mr_bl[2:0] gives the burst length BL: 0→1, 1→2, 2→4, 3→8, 7→full page, other codes→1. The precharge begins BL cycles after a read, whatever the CAS latency. It begins BL−1+TWR cycles after a write.
- R10: Mode set, refresh, self-refresh entry (refresh pattern with clock enable going low) and power-down entry (no-op with clock enable going low) each need both banks idle and at least TRP cycles since their precharge. Otherwise they report code 7. A mode set only takes effect when it is legal.
- R11: Code 8 is reported in two cases. The first is an activate fewer than TRC cycles after a refresh or after a self-refresh exit (clock enable sampled high again). The second is a refresh or self-refresh entry fewer than TRC cycles after a refresh.
- R12: A burst stop reports code 9 unless a burst is active. A burst is active for BL−1 cycles after a read or write to an open bank. A full-page burst stays active until a burst stop or a precharge of its bank.
- R13: After reset both banks are idle, the burst length is 1 and no error is shown. Each report is a one-cycle registered pulse carrying one code. When several rules fail, the code listed earliest for that command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, the SDRAM clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| cke | input | 1 | Clock enable |
| ba | input | 1 | Bank select |
| a10 | input | 1 | Address bit 10: auto-precharge or all-bank precharge |
| mr_bl | input | 3 | Burst-length field of the address, taken at a mode set |
| err_valid | output | 1 | One-cycle violation pulse |
| err_code | output | 4 | Code of the violated rule, 0 when none |

## Verification
A long scripted command stream puts every rule just below its limit and then exactly at its limit. A rule that is off by one cycle therefore fails in one direction or the other. Reads and writes with auto-precharge are followed by an activate both in the cycle the precharge starts and exactly TRP later. This separates the read formula from the write formula and catches any drift in the scheduled start. Precharges with A10 low and with A10 high are each followed by accesses to both banks, which shows whether one bank or both were closed. Bursts of length one, four and full page are each stopped early or late to exercise the burst-stop rule. Clock-enable sequences check that commands are ignored in power-down and self-refresh, and that the refresh spacing after self-refresh exit is enforced.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

    typedef enum logic [3:0] {
        C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST, C_SREF, C_PDE
    } cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE     = 4'd0,
        ERR_ACT_OPEN = 4'd1,
        ERR_RP       = 4'd2,
        ERR_RC       = 4'd3,
        ERR_RRD      = 4'd4,
        ERR_RCD      = 4'd5,
        ERR_CLOSED   = 4'd6,
        ERR_NOT_IDLE = 4'd7,
        ERR_REF_RC   = 4'd8,
        ERR_BSTOP    = 4'd9
    } err_e;

    typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_AP} bank_st_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // burst length selected by the 3-bit mode field
    function automatic int burst_len(input logic [2:0] code, input int page);
        case (code)
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            3'd7:    return page;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_chk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic cke_q,
    output cmd_e cmd
);
    cmd_e base;

    always_comb begin
        case ({ras_n, cas_n, we_n})
            3'b011:  base = C_ACT;
            3'b101:  base = C_RD;
            3'b100:  base = C_WR;
            3'b010:  base = C_PRE;
            3'b001:  base = C_REF;
            3'b000:  base = C_MRS;
            3'b110:  base = C_BST;
            default: base = C_NOP;
        endcase
        if (cs_n)
            base = C_NOP;
    end

    always_comb begin
        if (!cke_q)
            cmd = C_NOP;
        else if (!cke && base == C_REF)
            cmd = C_SREF;
        else if (!cke && base == C_NOP)
            cmd = C_PDE;
        else
            cmd = base;
    end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
    import sdram_chk_pkg::*;
#(
    parameter int CW  = 4,
    parameter int LIM = 8,
    parameter int AW  = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act_i,
    input  logic          acc_i,
    input  logic          ap_i,
    input  logic [AW-1:0] ap_len_i,
    input  logic          pre_i,
    output bank_st_e      st_o,
    output logic [CW-1:0] act_cnt_o,
    output logic [CW-1:0] rp_cnt_o
);
    localparam logic [CW-1:0] LIMV = CW'(LIM);

    logic [AW-1:0] ap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_o      <= ST_IDLE;
            act_cnt_o <= LIMV;
            rp_cnt_o  <= LIMV;
            ap_cnt    <= '0;
        end else begin
            if (act_cnt_o != LIMV) act_cnt_o <= act_cnt_o + 1'b1;
            if (rp_cnt_o != LIMV)  rp_cnt_o  <= rp_cnt_o + 1'b1;
            case (st_o)
                ST_IDLE: if (act_i) begin
                    st_o      <= ST_ACT;
                    act_cnt_o <= CW'(1);
                end
                ST_ACT: begin
                    if (pre_i) begin
                        st_o     <= ST_IDLE;
                        rp_cnt_o <= CW'(1);
                    end else if (acc_i && ap_i) begin
                        st_o   <= ST_AP;
                        ap_cnt <= ap_len_i;
                    end else if (act_i) begin
                        act_cnt_o <= CW'(1);
                    end
                end
                default: begin
                    if (ap_cnt == AW'(1)) begin
                        st_o     <= ST_IDLE;
                        rp_cnt_o <= CW'(1);
                        ap_cnt   <= '0;
                    end else begin
                        ap_cnt <= ap_cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // R9
    ap_pending_chk: assert property (@(posedge clk) disable iff (rst)
        st_o == ST_AP |-> ap_cnt != '0);

    // R8
    pre_close_chk: assert property (@(posedge clk) disable iff (rst)
        (pre_i && st_o == ST_ACT) |=> (st_o == ST_IDLE && rp_cnt_o == CW'(1)));

    // R2
    open_chk: assert property (@(posedge clk) disable iff (rst)
        (act_i && st_o == ST_IDLE) |=> (st_o == ST_ACT && act_cnt_o == CW'(1)));
endmodule

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker
    import sdram_chk_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int TRCD  = 3,
    parameter int TRRD  = 2,
    parameter int TRC   = 8,
    parameter int TRP   = 3,
    parameter int TWR   = 2,
    parameter int PAGE  = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    input  logic       cke,
    input  logic       ba,
    input  logic       a10,
    input  logic [2:0] mr_bl,
    output logic       err_valid,
    output logic [3:0] err_code
);
    localparam int LIM = imax(imax(TRC, TRP), imax(TRCD, TRRD));
    localparam int CW  = $clog2(LIM + 1);
    localparam int AW  = $clog2(PAGE + TWR + 1);
    localparam logic [CW-1:0] LIMV = CW'(LIM);

    cmd_e          cmd;
    logic          cke_q, in_sref, exit_edge;
    logic [2:0]    mr_q;
    bank_st_e      st      [NBANK];
    logic [CW-1:0] act_cnt [NBANK];
    logic [CW-1:0] rp_cnt  [NBANK];
    logic [CW-1:0] last_cnt, ref_cnt;
    logic          last_bank, burst_bank, burst_fp, burst_on, all_idle, is_acc;
    logic [AW-1:0] burst_left, bl_w, ap_len;
    err_e          code;

    sdram_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .cke_q(cke_q), .cmd(cmd)
    );

    assign bl_w      = AW'(burst_len(mr_q, PAGE));
    assign ap_len    = (cmd == C_WR) ? (bl_w - 1'b1 + AW'(TWR)) : bl_w;
    assign is_acc    = (cmd == C_RD) || (cmd == C_WR);
    assign exit_edge = !cke_q && cke;
    assign burst_on  = burst_fp || (burst_left != '0);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        sdram_bank_track #(.CW(CW), .LIM(LIM), .AW(AW)) u_bank (
            .clk(clk), .rst(rst),
            .act_i(cmd == C_ACT && ba == 1'(g)),
            .acc_i(is_acc && ba == 1'(g)),
            .ap_i(a10),
            .ap_len_i(ap_len),
            .pre_i(cmd == C_PRE && (a10 || ba == 1'(g))),
            .st_o(st[g]),
            .act_cnt_o(act_cnt[g]),
            .rp_cnt_o(rp_cnt[g])
        );
    end

    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < NBANK; i++)
            if (st[i] != ST_IDLE || rp_cnt[i] < CW'(TRP))
                all_idle = 1'b0;
    end

    // rule evaluation, earliest listed failure wins
    always_comb begin
        code = ERR_NONE;
        case (cmd)
            C_ACT: begin
                if (st[ba] == ST_ACT)                                code = ERR_ACT_OPEN;
                else if (st[ba] == ST_AP || rp_cnt[ba] < CW'(TRP))   code = ERR_RP;
                else if (act_cnt[ba] < CW'(TRC))                     code = ERR_RC;
                else if (last_cnt < CW'(TRRD) && last_bank != ba)    code = ERR_RRD;
                else if (ref_cnt < CW'(TRC))                         code = ERR_REF_RC;
            end
            C_RD, C_WR: begin
                if (st[ba] != ST_ACT)                code = ERR_CLOSED;
                else if (act_cnt[ba] < CW'(TRCD))    code = ERR_RCD;
            end
            C_REF, C_SREF: begin
                if (!all_idle)                   code = ERR_NOT_IDLE;
                else if (ref_cnt < CW'(TRC))     code = ERR_REF_RC;
            end
            C_MRS, C_PDE: if (!all_idle) code = ERR_NOT_IDLE;
            C_BST:        if (!burst_on) code = ERR_BSTOP;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke_q      <= 1'b1;
            in_sref    <= 1'b0;
            mr_q       <= 3'd0;
            last_cnt   <= LIMV;
            last_bank  <= 1'b0;
            ref_cnt    <= LIMV;
            burst_left <= '0;
            burst_fp   <= 1'b0;
            burst_bank <= 1'b0;
            err_valid  <= 1'b0;
            err_code   <= ERR_NONE;
        end else begin
            cke_q     <= cke;
            err_valid <= (code != ERR_NONE);
            err_code  <= code;

            if (cmd == C_SREF)      in_sref <= 1'b1;
            else if (exit_edge)     in_sref <= 1'b0;

            if (cmd == C_REF || (exit_edge && in_sref)) ref_cnt <= CW'(1);
            else if (ref_cnt != LIMV)                   ref_cnt <= ref_cnt + 1'b1;

            if (cmd == C_ACT) begin
                last_cnt  <= CW'(1);
                last_bank <= ba;
            end else if (last_cnt != LIMV) begin
                last_cnt <= last_cnt + 1'b1;
            end

            if (cmd == C_MRS && all_idle) mr_q <= mr_bl;

            if (is_acc && st[ba] == ST_ACT) begin
                burst_left <= bl_w - 1'b1;
                burst_fp   <= (mr_q == 3'd7);
                burst_bank <= ba;
            end else if (cmd == C_BST || (cmd == C_PRE && (a10 || ba == burst_bank))) begin
                burst_left <= '0;
                burst_fp   <= 1'b0;
            end else if (burst_left != '0) begin
                burst_left <= burst_left - 1'b1;
            end
        end
    end

    // R2
    act_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_ACT && st[ba] == ST_ACT) |=> (err_valid && err_code == ERR_ACT_OPEN));

    // R1
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_NOP) |=> !err_valid);

    // R12
    bstop_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_BST && !burst_on) |=> (err_valid && err_code == ERR_BSTOP));

    // R13
    pulse_code_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> err_code != ERR_NONE);
endmodule

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;
    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] ACT  = 4'b0011;
    localparam logic [3:0] RD   = 4'b0101;
    localparam logic [3:0] WR   = 4'b0100;
    localparam logic [3:0] PRE  = 4'b0010;
    localparam logic [3:0] REF  = 4'b0001;
    localparam logic [3:0] MRS  = 4'b0000;
    localparam logic [3:0] BST  = 4'b0110;
    localparam logic [3:0] DESA = 4'b1011;

    function automatic logic [9:0] mk(input logic [3:0] c, input logic b,
                                      input logic a, input logic [3:0] e);
        return {c, b, a, e};
    endfunction

    localparam int NV = 52;
    localparam logic [9:0] TBL [NV] = '{
        mk(MRS,0,0,0), mk(ACT,0,0,0), mk(ACT,1,0,4), mk(RD,0,0,5),
        mk(RD,0,0,0),  mk(BST,0,0,0), mk(BST,0,0,9), mk(ACT,0,0,1),
        mk(PRE,0,0,0), mk(RD,0,0,6),  mk(RD,1,0,0),  mk(ACT,0,0,3),
        mk(PRE,0,1,0), mk(REF,0,0,7), mk(NOP,0,0,0), mk(REF,0,0,8),
        mk(RD,1,0,6),  mk(ACT,1,0,8), mk(NOP,0,0,0), mk(NOP,0,0,0),
        mk(NOP,0,0,0), mk(NOP,0,0,0), mk(NOP,0,0,0), mk(ACT,0,0,0),
        mk(NOP,0,0,0), mk(NOP,0,0,0), mk(WR,0,1,0),  mk(RD,0,0,6),
        mk(NOP,0,0,0), mk(NOP,0,0,0), mk(NOP,0,0,0), mk(ACT,0,0,2),
        mk(NOP,0,0,0), mk(NOP,0,0,0), mk(ACT,0,0,0), mk(NOP,0,0,0),
        mk(NOP,0,0,0), mk(RD,0,1,0),  mk(MRS,0,0,7), mk(NOP,0,0,0),
        mk(NOP,0,0,0), mk(ACT,0,0,2), mk(NOP,0,0,0), mk(NOP,0,0,0),
        mk(ACT,0,0,0), mk(PRE,0,1,0), mk(NOP,0,0,0), mk(NOP,0,0,0),
        mk(NOP,0,0,0), mk(REF,0,0,0), mk(DESA,0,0,0), mk(RD,0,0,6)
    };

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic ba = 1'b0, a10 = 1'b0;
    logic [2:0] mr_bl = 3'd2;
    logic err_valid;
    logic [3:0] err_code;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_cmd_checker u_sdram_cmd_checker (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .a10(a10), .mr_bl(mr_bl),
        .err_valid(err_valid), .err_code(err_code)
    );

    function automatic string tag_of(input logic [3:0] e);
        case (e)
            4'd1: return "R2";  4'd2: return "R3";  4'd3: return "R4";
            4'd4: return "R5";  4'd5: return "R6";  4'd6: return "R7";
            4'd7: return "R10"; 4'd8: return "R11"; 4'd9: return "R12";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input logic [3:0] e, input string tag);
        tests++;
        if (err_valid !== (e != 4'd0) || err_code !== e) begin
            fails++;
            $display("FAIL %s: got valid=%0b code=%0d, expected valid=%0b code=%0d",
                     tag, err_valid, err_code, (e != 4'd0), e);
        end
    endtask

    task automatic step(input logic [3:0] c, input logic k, input logic b, input logic a,
                        input logic [2:0] m, input logic [3:0] e, input string tag);
        {cs_n, ras_n, cas_n, we_n} = c;
        cke = k; ba = b; a10 = a; mr_bl = m;
        @(posedge clk);
        @(negedge clk);
        check(e, tag);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(NOP, 1'b1, 1'b0, 1'b0, 3'd2, 4'd0, "R1");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no end, expected end of run");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(4'd0, "R13 reset");

        // table walk: one command per cycle, BL=4
        for (int i = 0; i < NV; i++) begin
            string t;
            t = (i == 31 || i == 34 || i == 41 || i == 44) ? "R9" : tag_of(TBL[i][3:0]);
            step(TBL[i][9:6], 1'b1, TBL[i][5], TBL[i][4], 3'd2, TBL[i][3:0], t);
        end

        // R8: single-bank precharge leaves the other bank open
        nops(5);
        step(ACT, 1, 0, 0, 3'd2, 4'd0, "R8");
        nops(1);
        step(ACT, 1, 1, 0, 3'd2, 4'd0, "R5 boundary");
        nops(2);
        step(PRE, 1, 0, 0, 3'd2, 4'd0, "R8");
        step(RD,  1, 1, 0, 3'd2, 4'd0, "R8 other bank open");
        step(RD,  1, 0, 0, 3'd2, 4'd6, "R8 selected bank closed");

        // R10: power-down entry with a bank open, then clean entry
        step(NOP, 0, 0, 0, 3'd2, 4'd7, "R10 pd entry open bank");
        step(NOP, 1, 0, 0, 3'd2, 4'd0, "R1 pd exit");
        step(PRE, 1, 0, 1, 3'd2, 4'd0, "R8");
        nops(3);
        step(NOP, 0, 0, 0, 3'd2, 4'd0, "R10 pd entry idle");
        step(ACT, 0, 0, 0, 3'd2, 4'd0, "R1 ignored in pd");
        step(NOP, 1, 0, 0, 3'd2, 4'd0, "R1 pd exit");
        step(RD,  1, 0, 0, 3'd2, 4'd6, "R1 act in pd had no effect");

        // R11: self-refresh exit spacing
        step(REF, 0, 0, 0, 3'd2, 4'd0, "R10 sref entry");
        step(ACT, 0, 0, 0, 3'd2, 4'd0, "R1 ignored in sref");
        step(NOP, 1, 0, 0, 3'd2, 4'd0, "R11 exit");
        nops(6);
        step(ACT, 1, 0, 0, 3'd2, 4'd8, "R11 one short");
        step(PRE, 1, 0, 1, 3'd2, 4'd0, "R8");
        nops(3);
        step(REF, 0, 0, 0, 3'd2, 4'd0, "R10 sref entry");
        step(NOP, 1, 0, 0, 3'd2, 4'd0, "R11 exit");
        nops(7);
        step(ACT, 1, 1, 0, 3'd2, 4'd0, "R11 boundary");

        // R12: full-page burst stays active
        step(PRE, 1, 0, 1, 3'd2, 4'd0, "R8");
        nops(3);
        step(MRS, 1, 0, 0, 3'd7, 4'd0, "R10 mode set");
        step(ACT, 1, 0, 0, 3'd2, 4'd0, "R12");
        nops(2);
        step(RD,  1, 0, 0, 3'd2, 4'd0, "R12");
        nops(20);
        step(BST, 1, 0, 0, 3'd2, 4'd0, "R12 full page active");
        step(BST, 1, 0, 0, 3'd2, 4'd9, "R12 after stop");

        // R12: burst length 1 has no active window
        step(PRE, 1, 0, 1, 3'd2, 4'd0, "R8");
        nops(3);
        step(MRS, 1, 0, 0, 3'd0, 4'd0, "R10 mode set");
        step(ACT, 1, 1, 0, 3'd2, 4'd0, "R12");
        nops(2);
        step(RD,  1, 1, 0, 3'd2, 4'd0, "R12");
        step(BST, 1, 1, 0, 3'd2, 4'd9, "R12 BL1");

        // R13: reset mid-run clears banks and report
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(4'd0, "R13 reset");
        rst = 1'b0;
        step(RD, 1, 1, 0, 3'd2, 4'd6, "R13 banks idle after reset");

        finish_run();
    end
endmodule